// File: doc/BRIEF.md
# Two-Channel Level Trigger Generator

This block sits in the sample clock domain beside a stream of 32-bit beats, each carrying two signed sample lanes. From those beats it builds a 32-bit trigger vector for a downstream capture-window detector. Every bit of the vector is its own condition. The conditions are a software manual trigger, a rising and a falling level crossing for each lane, and a field of user trigger bits that spare configuration inputs drive. Each crossing is judged against its own programmable threshold. Only beats with the valid flag high take part.

Each lane has a sample-history state machine with two states. `HIST_EMPTY` is entered at reset. On the first valid beat the machine takes `EMPTY->PRIMED`; `PRIMED` then holds until reset. A crossing can fire only in `PRIMED`, so the first valid sample after reset only loads the history.

The manual trigger has a state machine with three states: `MAN_IDLE`, `MAN_FIRE` and `MAN_HOLD`. A write strobe takes `IDLE->FIRE`. `FIRE` lasts one cycle and then goes `FIRE->HOLD` if the strobe is still high, or `FIRE->IDLE` if it is low. `HOLD` waits for the strobe to drop (`HOLD->IDLE`). As a result, one write of any length gives exactly one pulse.

Top module: `lvl_trig_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `trig_vec` is all zero.
- R2: The first valid beat after reset never sets a crossing bit (bits 4:1), whatever its sample values.
- R3: Bit 1 (lane A rising) is high for the one cycle after a valid beat whose lane A sample is at or above `thr_a_rise`, when the previous valid lane A sample was below it.
- R4: Bit 2 (lane A falling) is high for the one cycle after a valid beat whose lane A sample is below `thr_a_fall`, when the previous valid lane A sample was at or above it.
- R5: Bit 3 (lane B rising) follows the rule of R3 for lane B and `thr_b_rise`.
- R6: Bit 4 (lane B falling) follows the rule of R4 for lane B and `thr_b_fall`.
- R7: A beat with `s_valid` low neither sets a crossing bit in the following cycle nor changes the history that later crossings are judged against.
- R8: Lane A is `s_data[15:0]` and lane B is `s_data[31:16]`. Only the low 14 bits of each lane are used, read as a two's complement sample. The top two bits of each lane are ignored. Thresholds are 16-bit two's complement values.
- R9: Each write on `man_wr` (a run of one or more high cycles) produces exactly one single-cycle pulse on bit 0, in the cycle after the strobe's first high cycle.
- R10: Bits 31:16 equal the value of `user_trig` one cycle earlier.
- R11: Bits 15:5 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Beat qualifier; history and crossings use only beats where this is high |
| s_data | input | 32 | Packed lanes: A in 15:0, B in 31:16 |
| thr_a_rise | input | 16 | Lane A rising threshold, signed |
| thr_a_fall | input | 16 | Lane A falling threshold, signed |
| thr_b_rise | input | 16 | Lane B rising threshold, signed |
| thr_b_fall | input | 16 | Lane B falling threshold, signed |
| man_wr | input | 1 | Manual trigger register write strobe |
| user_trig | input | 16 | Spare configuration value for the user trigger field |
| trig_vec | output | 32 | Trigger vector for the window detector |

## Verification
The hardest case to reach from the ports is one where history matters but the current beat alone hides it. Such a beat is either a gap beat with `s_valid` low that carries a crossing value, or the first valid beat after reset that sits past a threshold. The stimulus places a valid low sample, then several invalid beats at a high value, then a valid beat at that high value. A correct block must fire a rise there, and a block that learned from the gap beats stays silent. The stimulus also opens each run with samples beyond the thresholds, to catch a history that starts at zero. The lane top bits carry non-sign patterns, so the sign comes only from bit 13. Manual strobes of several lengths and back-to-back shapes test the single-pulse rule.

// File: rtl/lvl_trig_pkg.sv
package lvl_trig_pkg;

    // Trigger vector bit positions (decoded by the window detector)
    localparam int TV_MAN     = 0;
    localparam int TV_A_RISE  = 1;
    localparam int TV_A_FALL  = 2;
    localparam int TV_B_RISE  = 3;
    localparam int TV_B_FALL  = 4;
    localparam int TV_USER_LO = 16;
    localparam int TV_LANE_STRIDE = 2;

    typedef enum logic {
        HIST_EMPTY,
        HIST_PRIMED
    } hist_state_t;

    typedef enum logic [1:0] {
        MAN_IDLE,
        MAN_FIRE,
        MAN_HOLD
    } man_state_t;

endpackage

// File: rtl/lvl_chan.sv
module lvl_chan
    import lvl_trig_pkg::*;
#(
    parameter int LANE_W   = 16,
    parameter int SAMPLE_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic        [LANE_W-1:0] lane,
    input  logic signed [LANE_W-1:0] thr_rise,
    input  logic signed [LANE_W-1:0] thr_fall,
    output logic                     rise_hit,
    output logic                     fall_hit
);

    logic signed [LANE_W-1:0] cur_s;
    logic signed [LANE_W-1:0] prev_q;
    hist_state_t              st_q;
    hist_state_t              st_d;

    // Sample extraction: sign taken from the sample MSB only
    generate
        if (LANE_W > SAMPLE_W) begin : g_ext
            logic unused_lane_hi;
            assign unused_lane_hi = ^lane[LANE_W-1:SAMPLE_W];
            assign cur_s = {{(LANE_W-SAMPLE_W){lane[SAMPLE_W-1]}}, lane[SAMPLE_W-1:0]};
        end else begin : g_full
            assign cur_s = lane;
        end
    endgenerate

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HIST_EMPTY:  if (smp_valid) st_d = HIST_PRIMED;
            HIST_PRIMED: st_d = HIST_PRIMED;
            default:     st_d = HIST_EMPTY;
        endcase
    end

    // State and history register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= HIST_EMPTY;
            prev_q <= '0;
        end else begin
            st_q <= st_d;
            if (smp_valid) prev_q <= cur_s;
        end
    end

    // Outputs
    always_comb begin
        rise_hit = 1'b0;
        fall_hit = 1'b0;
        unique case (st_q)
            HIST_EMPTY: begin
                rise_hit = 1'b0;
                fall_hit = 1'b0;
            end
            HIST_PRIMED: begin
                rise_hit = smp_valid && (prev_q < thr_rise) && (cur_s >= thr_rise);
                fall_hit = smp_valid && (prev_q >= thr_fall) && (cur_s < thr_fall);
            end
            default: begin
                rise_hit = 1'b0;
                fall_hit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lvl_man_fsm.sv
module lvl_man_fsm
    import lvl_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_strobe,
    output logic pulse
);

    man_state_t st_q;
    man_state_t st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MAN_IDLE: if (wr_strobe) st_d = MAN_FIRE;
            MAN_FIRE: st_d = wr_strobe ? MAN_HOLD : MAN_IDLE;
            MAN_HOLD: if (!wr_strobe) st_d = MAN_IDLE;
            default:  st_d = MAN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MAN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            MAN_FIRE: pulse = 1'b1;
            default:  pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/lvl_trig_gen.sv
module lvl_trig_gen
    import lvl_trig_pkg::*;
#(
    parameter int LANE_W   = 16,
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_valid,
    input  logic [2*LANE_W-1:0] s_data,
    input  logic [LANE_W-1:0]   thr_a_rise,
    input  logic [LANE_W-1:0]   thr_a_fall,
    input  logic [LANE_W-1:0]   thr_b_rise,
    input  logic [LANE_W-1:0]   thr_b_fall,
    input  logic                man_wr,
    input  logic [2*LANE_W-TV_USER_LO-1:0] user_trig,
    output logic [2*LANE_W-1:0] trig_vec
);

    localparam int NUM_CH = 2;
    localparam int VEC_W  = NUM_CH * LANE_W;
    localparam int USER_W = VEC_W - TV_USER_LO;

    logic signed [LANE_W-1:0] thr_r [NUM_CH];
    logic signed [LANE_W-1:0] thr_f [NUM_CH];
    logic [NUM_CH-1:0]        rise_v;
    logic [NUM_CH-1:0]        fall_v;
    logic                     man_pulse;
    logic [VEC_W-1:0]         vec_d;
    logic [VEC_W-1:0]         vec_q;

    assign thr_r[0] = thr_a_rise;
    assign thr_f[0] = thr_a_fall;
    assign thr_r[1] = thr_b_rise;
    assign thr_f[1] = thr_b_fall;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
            lvl_chan #(
                .LANE_W   (LANE_W),
                .SAMPLE_W (SAMPLE_W)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .smp_valid (s_valid),
                .lane      (s_data[c*LANE_W +: LANE_W]),
                .thr_rise  (thr_r[c]),
                .thr_fall  (thr_f[c]),
                .rise_hit  (rise_v[c]),
                .fall_hit  (fall_v[c])
            );
        end
    endgenerate

    lvl_man_fsm u_man (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (man_wr),
        .pulse     (man_pulse)
    );

    always_comb begin
        vec_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            vec_d[TV_A_RISE + TV_LANE_STRIDE*c] = rise_v[c];
            vec_d[TV_A_FALL + TV_LANE_STRIDE*c] = fall_v[c];
        end
        vec_d[TV_USER_LO +: USER_W] = user_trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign trig_vec = {vec_q[VEC_W-1:TV_MAN+1], man_pulse};

endmodule

// File: rtl/lvl_trig_gen_chk.sv
module lvl_trig_gen_chk
    import lvl_trig_pkg::*;
#(
    parameter int VEC_W  = 32,
    parameter int USER_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              man_wr,
    input logic [USER_W-1:0] user_trig,
    input logic [VEC_W-1:0]  trig_vec
);

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trig_vec[TV_USER_LO-1:TV_B_FALL+1] == '0);

    a_r7_gap_beat_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> (trig_vec[TV_B_FALL:TV_A_RISE] == '0));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        trig_vec[TV_MAN] |=> !trig_vec[TV_MAN]);

    a_r9_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        trig_vec[TV_MAN] |-> $past(man_wr));

    a_r10_user_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (trig_vec[VEC_W-1:TV_USER_LO] == $past(user_trig)));

    a_r3_r4_lane_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_vec[TV_A_RISE] && trig_vec[TV_A_FALL]));

    a_r5_r6_lane_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_vec[TV_B_RISE] && trig_vec[TV_B_FALL]));

endmodule

bind lvl_trig_gen lvl_trig_gen_chk #(
    .VEC_W  (VEC_W),
    .USER_W (USER_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .man_wr    (man_wr),
    .user_trig (user_trig),
    .trig_vec  (trig_vec)
);

// File: tb/lvl_trig_gen_test.sv
module lvl_trig_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic [15:0] thr_a_rise = '0, thr_a_fall = '0, thr_b_rise = '0, thr_b_fall = '0;
    logic        man_wr = 1'b0;
    logic [15:0] user_trig = '0;
    logic [31:0] trig_vec;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    bit    live = 0;
    string phase = "R1 reset";

    // reference model state
    bit          has_prev = 0;
    bit          wr_prev = 0;
    int          pa, pb, ca, cb;
    logic [31:0] exp_vec = '0;

    always #2 clk = ~clk;   // 250 MHz

    lvl_trig_gen uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .thr_a_rise(thr_a_rise), .thr_a_fall(thr_a_fall),
        .thr_b_rise(thr_b_rise), .thr_b_fall(thr_b_fall),
        .man_wr(man_wr), .user_trig(user_trig), .trig_vec(trig_vec)
    );

    function automatic int smp(input logic [15:0] l);
        return int'($signed(l[13:0]));
    endfunction

    function automatic int thr(input logic [15:0] t);
        return int'($signed(t));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            live = 0; has_prev = 0; wr_prev = 0; exp_vec = '0;
        end else begin
            exp_vec = '0;
            ca = smp(s_data[15:0]);
            cb = smp(s_data[31:16]);
            exp_vec[0] = man_wr && !wr_prev;
            if (s_valid && has_prev) begin
                exp_vec[1] = (pa <  thr(thr_a_rise)) && (ca >= thr(thr_a_rise));
                exp_vec[2] = (pa >= thr(thr_a_fall)) && (ca <  thr(thr_a_fall));
                exp_vec[3] = (pb <  thr(thr_b_rise)) && (cb >= thr(thr_b_rise));
                exp_vec[4] = (pb >= thr(thr_b_fall)) && (cb <  thr(thr_b_fall));
            end
            if (s_valid) begin
                pa = ca; pb = cb; has_prev = 1;
            end
            exp_vec[31:16] = user_trig;
            wr_prev = man_wr;
            live = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0t: actual %h expected %h", tag, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && live && !done) begin
            chk("R9 manual bit",   32'(trig_vec[0]),     32'(exp_vec[0]));
            chk("R3 A rise bit",   32'(trig_vec[1]),     32'(exp_vec[1]));
            chk("R4 A fall bit",   32'(trig_vec[2]),     32'(exp_vec[2]));
            chk("R5 B rise bit",   32'(trig_vec[3]),     32'(exp_vec[3]));
            chk("R6 B fall bit",   32'(trig_vec[4]),     32'(exp_vec[4]));
            chk("R11 reserved",    32'(trig_vec[15:5]),  32'(exp_vec[15:5]));
            chk("R10 user field",  32'(trig_vec[31:16]), 32'(exp_vec[31:16]));
        end
    end

    task automatic beat(input bit v, input int a, input int b);
        @(negedge clk);
        s_valid = v;
        s_data  = {b[15:0], a[15:0]};
    endtask

    task automatic beat_raw(input bit v, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        s_valid = v;
        s_data  = {b, a};
    endtask

    task automatic strobe(input int hi, input int lo);
        for (int i = 0; i < hi; i++) begin @(negedge clk); man_wr = 1'b1; end
        for (int i = 0; i < lo; i++) begin @(negedge clk); man_wr = 1'b0; end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual run still going, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        thr_a_rise = 16'(100);
        thr_a_fall = 16'(-100);
        thr_b_rise = 16'(0);
        thr_b_fall = 16'(500);
        user_trig  = 16'hBEEF;
        man_wr     = 1'b1;
        s_valid    = 1'b1;
        s_data     = 32'h1FFF_1FFF;
        repeat (3) @(negedge clk);
        chk("R1 reset value", trig_vec, 32'h0);
        s_valid = 1'b0; man_wr = 1'b0; user_trig = '0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle after reset", trig_vec, 32'h0);

        // R2: first valid sample beyond every threshold must not fire
        phase = "R2 first valid beat";
        beat(0, 500, 600);
        beat(1, 500, 600);
        beat(1, 500, 600);

        phase = "R3 R4 R5 R6 crossings";
        beat(1, 99, 499);     // B falls below 500
        beat(1, 100, -1);     // A rise at threshold exactly
        beat(1, 100, 0);      // B rise at threshold exactly
        beat(1, -100, 500);   // A at fall threshold: no fall
        beat(1, -101, 499);   // A fall, B fall
        beat(1, -101, 499);
        beat(1, 100, -5);
        beat(1, 8191, 8191);
        beat(1, -8192, -8192);
        beat(1, 8191, 8191);

        // R7: gap beats carry crossing values but must be ignored
        phase = "R7 invalid beats";
        beat(1, 0, -10);
        beat(0, 500, 600);
        beat(0, 500, 600);
        beat(0, -500, -600);
        beat(1, 500, 600);    // rise judged against 0 / -10
        beat(0, -300, 100);
        beat(1, 500, 600);

        // R8: lane top bits are not sign bits
        phase = "R8 lane top bits";
        beat_raw(1, 16'h0000, 16'h0258);   // A 0, B 600
        beat_raw(1, 16'h7E00, 16'h4005);   // A -512 (fall), B 5 (fall)
        beat_raw(1, 16'h8064, 16'hBFFF);   // A 100 (rise), B -1
        beat_raw(1, 16'h4000, 16'h4000);   // A 0, B 0 (rise)

        // threshold extremes
        phase = "R3 R4 extreme thresholds";
        thr_a_rise = 16'(-8192);
        thr_a_fall = 16'(8191);
        beat(1, -8192, 0);
        beat(1, 8191, 0);
        beat(1, 8190, 0);     // A fall from 8191
        beat(1, -8192, 0);
        s_valid = 1'b0;

        // R9: manual strobes of several shapes
        phase = "R9 manual strobes";
        strobe(1, 3);
        strobe(3, 2);
        strobe(1, 1);
        strobe(1, 1);
        strobe(6, 1);
        strobe(2, 4);

        // R10: user field
        phase = "R10 user field";
        foreach (s_data[i]) begin
            if (i < 6) begin @(negedge clk); user_trig = 16'(16'hA5A5 ^ (16'h1111 * i)); end
        end
        @(negedge clk); user_trig = 16'hFFFF;
        @(negedge clk); user_trig = 16'h0000;

        // mixed random traffic
        phase = "R2 R7 R8 R9 R10 random traffic";
        thr_a_rise = 16'(-37);
        thr_a_fall = 16'(-37);
        thr_b_rise = 16'(1200);
        thr_b_fall = 16'(-900);
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            s_valid   = ($urandom % 4) != 0;
            s_data    = {$urandom} & 32'hCFFF_CFFF | (($urandom % 2 == 0) ? 32'h3000_3000 : 32'h0);
            man_wr    = ($urandom % 3) == 0;
            user_trig = 16'($urandom);
            if (k == 2000) begin
                rst_n = 1'b0;
                @(negedge clk);
                rst_n = 1'b1;
            end
        end
        @(negedge clk);
        s_valid = 1'b0; man_wr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule